// File: doc/BRIEF.md
# Tag-Only Reservation Station Array

This block holds the waiting instructions of an out-of-order core that keeps every operand value in one physical register file. It has five stations, one for each functional unit class: integer ALU, load, store, first FP unit and second FP unit. A station stores only control information: an opcode, a destination physical tag and two source physical tags, each with a ready bit. It never stores an operand value. The functional units read their operands from the register file after they issue.

The dispatch stage writes one instruction per cycle into the station of its class. The initial readiness of each source comes from the map table's ready bit for that tag. A completion bus carries only a physical tag. Every busy station compares that tag with its source tags and marks each matching source ready. A station whose used sources are all ready raises an issue request. An issue grant frees the station, and so does a squash during rollback. A dispatch aimed at an occupied station is stalled.

Top module: `tag_rs_array`

## Requirements
- R1: After reset all five stations are free, and no issue request or source ready bit is set.
- R2: The class code selects the station: 0 integer ALU, 1 load, 2 store, 3 first FP, 4 second FP. When the target station is free, a dispatch writes its opcode, destination tag and source tags there, and the station reads busy from the next cycle.
- R3: A dispatch whose target station is busy raises `disp_stall` in the same cycle. The stored contents of that station are left unchanged.
- R4: The store station (code 2) has no destination. Its destination tag output always reads 0.
- R5: At dispatch, a used source takes its ready bit from the map table ready input. An unused source is written as ready.
- R6: A completion tag that arrives in the same cycle as a dispatch, and that equals a used source tag of that dispatch, marks that source ready.
- R7: While a station is busy, a completion tag equal to one of its source tags sets that source's ready bit from the next cycle. Ready bits never clear while the station stays busy, and a tag that does not match changes nothing.
- R8: `issue_req[i]` is high exactly when station i is busy and both of its source ready bits are set.
- R9: A grant on a requesting station frees it on the next cycle. A grant on a station that is not requesting is ignored.
- R10: A squash bit on a busy station frees that station on the next cycle.
- R11: Class codes 5 to 7 write no station and never stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| disp_valid | input | 1 | Dispatch request this cycle |
| disp_class | input | 3 | Target station code |
| disp_op | input | OP_W | Opcode to store |
| disp_dst | input | TAG_W | Destination physical tag |
| disp_use1 | input | 1 | First source is used |
| disp_src1 | input | TAG_W | First source tag |
| disp_rdy1 | input | 1 | Map table ready bit for the first source |
| disp_use2 | input | 1 | Second source is used |
| disp_src2 | input | TAG_W | Second source tag |
| disp_rdy2 | input | 1 | Map table ready bit for the second source |
| disp_stall | output | 1 | Dispatch rejected because the target station is busy |
| cmpl_valid | input | 1 | Completion bus carries a tag |
| cmpl_tag | input | TAG_W | Completing physical tag |
| issue_grant | input | 5 | Per-station issue grant |
| squash | input | 5 | Per-station free on rollback |
| issue_req | output | 5 | Per-station issue request |
| busy | output | 5 | Per-station occupied flag |
| src1_rdy | output | 5 | Per-station first source ready |
| src2_rdy | output | 5 | Per-station second source ready |
| ent_op | output | 5*OP_W | Stored opcodes, station i at slice i |
| ent_dst | output | 5*TAG_W | Stored destination tags |
| ent_src1 | output | 5*TAG_W | Stored first source tags |
| ent_src2 | output | 5*TAG_W | Stored second source tags |

## Verification
The bench targets a completion tag that arrives in the same cycle as the dispatch reading it. A design that missed this would leave the source waiting for a broadcast that has already passed, and the station would never issue. It targets a dispatch into an occupied station. Without the stall, that dispatch would overwrite a live entry, or, with a stall but a write anyway, would corrupt the tags. It also targets grants on stations that are not requesting and squashes that overlap grants and wakeups. Freeing a station on an unrequested grant would silently drop an instruction. A random phase with a small tag space produces frequent tag matches, and every output is compared each cycle with a behavioural model.

// File: rtl/tag_rs_array.sv
module tag_rs_array #(
  parameter int TAG_W = 6,
  parameter int OP_W  = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 disp_valid,
  input  logic [2:0]           disp_class,
  input  logic [OP_W-1:0]      disp_op,
  input  logic [TAG_W-1:0]     disp_dst,
  input  logic                 disp_use1,
  input  logic [TAG_W-1:0]     disp_src1,
  input  logic                 disp_rdy1,
  input  logic                 disp_use2,
  input  logic [TAG_W-1:0]     disp_src2,
  input  logic                 disp_rdy2,
  output logic                 disp_stall,
  input  logic                 cmpl_valid,
  input  logic [TAG_W-1:0]     cmpl_tag,
  input  logic [4:0]           issue_grant,
  input  logic [4:0]           squash,
  output logic [4:0]           issue_req,
  output logic [4:0]           busy,
  output logic [4:0]           src1_rdy,
  output logic [4:0]           src2_rdy,
  output logic [5*OP_W-1:0]    ent_op,
  output logic [5*TAG_W-1:0]   ent_dst,
  output logic [5*TAG_W-1:0]   ent_src1,
  output logic [5*TAG_W-1:0]   ent_src2
);
  localparam int NST = 5;
  localparam int ST_IDX = 2;

  logic [NST-1:0] busy_q, r1_q, r2_q;
  logic [OP_W-1:0]  op_q  [NST];
  logic [TAG_W-1:0] dst_q [NST];
  logic [TAG_W-1:0] s1_q  [NST];
  logic [TAG_W-1:0] s2_q  [NST];

  logic cls_ok;
  logic hit1_new, hit2_new;

  assign cls_ok     = disp_class < 3'd5;
  assign disp_stall = disp_valid && cls_ok && busy_q[disp_class];
  assign hit1_new   = cmpl_valid && (cmpl_tag == disp_src1);
  assign hit2_new   = cmpl_valid && (cmpl_tag == disp_src2);

  assign busy      = busy_q;
  assign src1_rdy  = r1_q;
  assign src2_rdy  = r2_q;
  assign issue_req = busy_q & r1_q & r2_q;

  for (genvar i = 0; i < NST; i++) begin : g_st
    localparam logic [2:0] IDX = 3'(i);
    logic wr, free, hit1, hit2;

    assign wr   = disp_valid && (disp_class == IDX) && !busy_q[i];
    assign free = squash[i] || (issue_grant[i] && issue_req[i]);
    assign hit1 = cmpl_valid && (cmpl_tag == s1_q[i]);
    assign hit2 = cmpl_valid && (cmpl_tag == s2_q[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        busy_q[i] <= 1'b0;
        r1_q[i]   <= 1'b0;
        r2_q[i]   <= 1'b0;
        op_q[i]   <= '0;
        dst_q[i]  <= '0;
        s1_q[i]   <= '0;
        s2_q[i]   <= '0;
      end else if (busy_q[i]) begin
        if (free) begin
          busy_q[i] <= 1'b0;
          r1_q[i]   <= 1'b0;
          r2_q[i]   <= 1'b0;
        end else begin
          if (hit1) r1_q[i] <= 1'b1;
          if (hit2) r2_q[i] <= 1'b1;
        end
      end else if (wr) begin
        busy_q[i] <= 1'b1;
        op_q[i]   <= disp_op;
        dst_q[i]  <= (i == ST_IDX) ? '0 : disp_dst;
        s1_q[i]   <= disp_src1;
        s2_q[i]   <= disp_src2;
        r1_q[i]   <= !disp_use1 || disp_rdy1 || hit1_new;
        r2_q[i]   <= !disp_use2 || disp_rdy2 || hit2_new;
      end
    end

    assign ent_op[i*OP_W +: OP_W]     = op_q[i];
    assign ent_dst[i*TAG_W +: TAG_W]  = dst_q[i];
    assign ent_src1[i*TAG_W +: TAG_W] = s1_q[i];
    assign ent_src2[i*TAG_W +: TAG_W] = s2_q[i];
  end
endmodule

module tag_rs_array_chk #(
  parameter int TAG_W = 6,
  parameter int OP_W  = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               disp_valid,
  input logic [2:0]         disp_class,
  input logic [TAG_W-1:0]   disp_src1,
  input logic               disp_stall,
  input logic               cmpl_valid,
  input logic [TAG_W-1:0]   cmpl_tag,
  input logic [4:0]         issue_grant,
  input logic [4:0]         squash,
  input logic [4:0]         issue_req,
  input logic [4:0]         busy,
  input logic [4:0]         src1_rdy,
  input logic [5*TAG_W-1:0] ent_dst,
  input logic [5*TAG_W-1:0] ent_src1
);
  // R4
  st_dst_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ent_dst[2*TAG_W +: TAG_W] == '0);

  for (genvar i = 0; i < 5; i++) begin : g_chk
    localparam logic [2:0] IDX = 3'(i);
    logic keep;
    assign keep = !squash[i] && !(issue_grant[i] && issue_req[i]);

    // R2
    disp_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid && !disp_stall && disp_class == IDX
      |=> busy[i] && ent_src1[i*TAG_W +: TAG_W] == $past(disp_src1));
    // R3
    stall_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid && disp_stall && disp_class == IDX && keep
      |=> busy[i] && $stable(ent_src1[i*TAG_W +: TAG_W]));
    // R7
    wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy[i] && keep && cmpl_valid && cmpl_tag == ent_src1[i*TAG_W +: TAG_W]
      |=> src1_rdy[i]);
    // R7
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy[i] && src1_rdy[i] && keep |=> src1_rdy[i]);
    // R9
    grant_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue_grant[i] && issue_req[i] |=> !busy[i]);
    // R10
    squash_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      squash[i] && busy[i] |=> !busy[i]);
  end
endmodule

bind tag_rs_array tag_rs_array_chk #(.TAG_W(TAG_W), .OP_W(OP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_class(disp_class),
  .disp_src1(disp_src1), .disp_stall(disp_stall), .cmpl_valid(cmpl_valid),
  .cmpl_tag(cmpl_tag), .issue_grant(issue_grant), .squash(squash),
  .issue_req(issue_req), .busy(busy), .src1_rdy(src1_rdy),
  .ent_dst(ent_dst), .ent_src1(ent_src1)
);

// File: tb/test_tag_rs_array.sv
module test_tag_rs_array;
  localparam int TW = 6;
  localparam int OW = 5;

  logic clk = 0, rst_n = 0;
  logic dv = 0, u1 = 0, u2 = 0, mr1 = 0, mr2 = 0, cv = 0;
  logic [2:0] cls = 0;
  logic [OW-1:0] op = 0;
  logic [TW-1:0] dst = 0, s1 = 0, s2 = 0, ct = 0;
  logic [4:0] gnt = 0, sq = 0;
  logic stall;
  logic [4:0] req, bsy, r1, r2;
  logic [5*OW-1:0] eop;
  logic [5*TW-1:0] edst, es1, es2;

  always #5 clk = ~clk;

  tag_rs_array #(.TAG_W(TW), .OP_W(OW)) i_tag_rs_array (
    .clk(clk), .rst_n(rst_n), .disp_valid(dv), .disp_class(cls), .disp_op(op),
    .disp_dst(dst), .disp_use1(u1), .disp_src1(s1), .disp_rdy1(mr1),
    .disp_use2(u2), .disp_src2(s2), .disp_rdy2(mr2), .disp_stall(stall),
    .cmpl_valid(cv), .cmpl_tag(ct), .issue_grant(gnt), .squash(sq),
    .issue_req(req), .busy(bsy), .src1_rdy(r1), .src2_rdy(r2),
    .ent_op(eop), .ent_dst(edst), .ent_src1(es1), .ent_src2(es2));

  int tests = 0, fails = 0, cyc = 0;
  bit m_b[5], m_r1[5], m_r2[5];
  int m_op[5], m_dst[5], m_s1[5], m_s2[5];

  task automatic chk(string rq, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", rq, act, exp, cyc);
    end
  endtask

  // reference model: behavioural, updated on each rising edge
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      for (int i = 0; i < 5; i++) begin
        m_b[i] = 0; m_r1[i] = 0; m_r2[i] = 0;
      end
    end else begin
      bit rq[5];
      for (int i = 0; i < 5; i++) rq[i] = m_b[i] && m_r1[i] && m_r2[i];
      for (int i = 0; i < 5; i++) begin
        if (m_b[i]) begin
          if (sq[i] || (gnt[i] && rq[i])) begin
            m_b[i] = 0; m_r1[i] = 0; m_r2[i] = 0;
          end else begin
            if (cv && int'(ct) == m_s1[i]) m_r1[i] = 1;
            if (cv && int'(ct) == m_s2[i]) m_r2[i] = 1;
          end
        end else if (dv && int'(cls) == i) begin
          m_b[i] = 1; m_op[i] = int'(op);
          m_dst[i] = (i == 2) ? 0 : int'(dst);
          m_s1[i] = int'(s1); m_s2[i] = int'(s2);
          m_r1[i] = !u1 || mr1 || (cv && ct == s1);
          m_r2[i] = !u2 || mr2 || (cv && ct == s2);
        end
      end
    end
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  always @(negedge clk) if (rst_n) begin
    int eb, er, e1, e2;
    eb = 0; er = 0; e1 = 0; e2 = 0;
    for (int i = 0; i < 5; i++) begin
      eb |= int'(m_b[i]) << i;
      e1 |= int'(m_r1[i]) << i;
      e2 |= int'(m_r2[i]) << i;
      er |= int'(m_b[i] && m_r1[i] && m_r2[i]) << i;
      if (m_b[i]) begin
        chk("R2 op", int'(eop[i*OW +: OW]), m_op[i]);
        chk("R2/R4 dst", int'(edst[i*TW +: TW]), m_dst[i]);
        chk("R2 src1", int'(es1[i*TW +: TW]), m_s1[i]);
        chk("R2 src2", int'(es2[i*TW +: TW]), m_s2[i]);
      end
    end
    chk("R2/R9/R10 busy", int'(bsy), eb);
    chk("R8 issue_req", int'(req), er);
    chk("R5/R7 src1_rdy", int'(r1), e1);
    chk("R5/R7 src2_rdy", int'(r2), e2);
    chk("R3/R11 stall", int'(stall), int'(dv && cls < 5 && m_b[cls]));
  end

  task automatic idle();
    dv = 0; cv = 0; gnt = 0; sq = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", int'(bsy), 0);
    chk("R1 req", int'(req), 0);
    chk("R1 rdy", int'(r1 | r2), 0);
    #1 rst_n = 1;

    // R6: completion of src1 in the dispatch cycle
    dv = 1; cls = 0; op = 7; dst = 20; u1 = 1; s1 = 9; mr1 = 0;
    u2 = 1; s2 = 10; mr2 = 0; cv = 1; ct = 9;
    @(negedge clk);
    chk("R6 src1 ready", int'(r1[0]), 1);
    chk("R5 src2 waiting", int'(r2[0]), 0);
    #1 idle(); cv = 1; ct = 10;
    @(negedge clk);
    chk("R7 wake src2", int'(r2[0]), 1);
    chk("R8 request", int'(req[0]), 1);
    #1 idle(); cv = 1; ct = 33;
    @(negedge clk);
    chk("R7 no-match keeps", int'(busy_bit(0)), 1);
    #1 idle(); gnt = 5'b00001;
    @(negedge clk);
    chk("R9 grant frees", int'(bsy[0]), 0);

    // R11: unused code
    #1 idle(); dv = 1; cls = 6;
    @(negedge clk);
    chk("R11 no stall", int'(stall), 0);
    #1 idle();
    @(negedge clk);
    chk("R11 no write", int'(bsy), 0);

    // R4 / R5: store, sources unused
    #1 idle(); dv = 1; cls = 2; dst = 33; u1 = 0; u2 = 0; s1 = 4; s2 = 5;
    @(negedge clk);
    chk("R4 store dst", int'(edst[2*TW +: TW]), 0);
    chk("R5 unused ready", int'(req[2]), 1);
    // R9: grant on a non-requesting entry ignored
    #1 idle(); dv = 1; cls = 1; u1 = 1; mr1 = 0; s1 = 12; u2 = 0;
    @(negedge clk);
    #1 idle(); gnt = 5'b00010;
    @(negedge clk);
    chk("R9 ignored grant", int'(bsy[1]), 1);
    // R3: dispatch into busy store station
    #1 idle(); dv = 1; cls = 2; s1 = 44; u1 = 1;
    @(negedge clk);
    chk("R3 stall", int'(stall), 1);
    #1 idle();
    @(negedge clk);
    chk("R3 unchanged", int'(es1[2*TW +: TW]), 4);
    // R10 squash
    #1 idle(); sq = 5'b00110;
    @(negedge clk);
    chk("R10 squash", int'(bsy), 0);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      #1;
      dv = $urandom % 2; cls = 3'($urandom % 8); op = OW'($urandom);
      dst = TW'($urandom % 16); s1 = TW'($urandom % 16); s2 = TW'($urandom % 16);
      u1 = $urandom % 4 != 0; u2 = $urandom % 3 != 0;
      mr1 = $urandom % 3 == 0; mr2 = $urandom % 3 == 0;
      cv = $urandom % 2; ct = TW'($urandom % 16);
      gnt = 5'($urandom);
      sq = ($urandom % 10 == 0) ? 5'($urandom) : 5'd0;
      @(negedge clk);
    end
    #1 idle();
    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  function automatic logic busy_bit(int i);
    return bsy[i];
  endfunction
endmodule